// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands, one clock cycle per operand bit, and needs only one adder as wide as an operand. A single register of twice the operand width holds the result. When a request is accepted, its lower half takes the multiplier and its upper half is cleared. On every step the block looks at the register's least significant bit. When that bit is set, the multiplicand is added into the upper half. The whole register then moves right by one place, and the adder's carry enters at the top. The multiplier bits are consumed from the bottom of the register while product bits fill it from above.

A caller raises `go` for one cycle with both operands present. `busy` stays high while the steps run. `fin` pulses for one cycle when the last step has completed. From that point `prod` keeps its value until the next accepted request. A `go` that arrives while a multiply is running is dropped.

Top module: `seq_mul`

## Requirements
- R1: After reset, `busy` is 0, `fin` is 0 and `prod` is all zeros.
- R2: A `go` sampled high while `busy` is 0 starts a multiply, and `busy` reads 1 from the next cycle on.
- R3: `busy` stays high for exactly W cycles (W = operand width, default 32). In the cycle after the last of them, `busy` is 0 and `fin` is 1.
- R4: `fin` is high for a single cycle only, and only right after a multiply has finished.
- R5: When `fin` is high, `prod` equals the unsigned product of the operands captured at start, over the full 2W bits, without truncation.
- R6: The carry out of the upper-half addition is kept in the product, so an all-ones times all-ones multiply gives 0xFFFFFFFE00000001 at W = 32.
- R7: A `go` sampled high while `busy` is 1 is ignored. The running result and its timing do not change, and operand changes during a multiply have no effect.
- R8: While idle, `prod` holds the last result until the next accepted `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start request, sampled each cycle |
| mcand | input | W | Multiplicand, unsigned |
| mplier | input | W | Multiplier, unsigned |
| busy | output | 1 | Multiply in progress |
| fin | output | 1 | One-cycle pulse when the result is ready |
| prod | output | 2W | Product register |

## Verification
The hardest case to reach is the carry out of the upper-half addition. It is set only when the partial sum in the upper half overflows, which needs large operands on both sides. The bench drives all-ones against all-ones and against other high-valued patterns to reach it. It also raises `go` in the middle of a multiply while changing the operands on the same cycles, to confirm that the result and the finish cycle are unchanged.

// File: rtl/seq_mul.sv
module seq_mul #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           busy,
  output logic           fin,
  output logic [2*W-1:0] prod
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  mc_q;
  logic [CW-1:0] left_q;
  logic [W:0]    sum;

  assign sum = {1'b0, prod[2*W-1:W]} + (prod[0] ? {1'b0, mc_q} : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      fin    <= 1'b0;
      prod   <= '0;
      mc_q   <= '0;
      left_q <= '0;
    end else begin
      fin <= 1'b0;
      if (busy) begin
        prod   <= {sum, prod[W-1:1]};
        left_q <= left_q - 1'b1;
        if (left_q == CW'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end else if (go) begin
        busy   <= 1'b1;
        mc_q   <= mcand;
        prod   <= {{W{1'b0}}, mplier};
        left_q <= CW'(W);
      end
    end
  end
endmodule

module seq_mul_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           go,
  input logic           busy,
  input logic           fin,
  input logic [2*W-1:0] prod
);
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> busy);
  a_r4_fin_single: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
  a_r4_fin_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin) |-> $fell(busy));
  a_r3_fin_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !busy);
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go) |=> $stable(prod));
endmodule

bind seq_mul seq_mul_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .fin(fin), .prod(prod)
);

// File: tb/test_seq_mul.sv
module test_seq_mul;
  localparam int W = 32;
  logic clk = 0, rst_n = 0, go = 0;
  logic [W-1:0] mcand = 0, mplier = 0;
  logic busy, fin;
  logic [2*W-1:0] prod;
  int total = 0, bad = 0;
  logic [2*W-1:0] expq[$];
  bit watchdog_hit = 0;

  always #4 clk = ~clk;

  seq_mul #(.W(W)) i_seq_mul (.*);

  task automatic check(string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [W-1:0] a, logic [W-1:0] b, bit poke);
    @(negedge clk);
    mcand = a; mplier = b; go = 1;
    expq.push_back({{W{1'b0}}, a} * {{W{1'b0}}, b});
    @(negedge clk);
    go = 0;
    check("R2 busy after go", {63'd0, busy}, 64'd1);
    for (int i = 1; i < W; i++) begin
      if (poke && i == 5) begin go = 1; mcand = ~a; mplier = ~b; end
      if (poke && i == 6) go = 0;
      @(negedge clk);
    end
    check("R3 busy for W cycles", {63'd0, busy}, 64'd1);
    @(negedge clk);
    check("R3 busy low at finish", {63'd0, busy}, 64'd0);
    check("R3 fin at finish", {63'd0, fin}, 64'd1);
    @(negedge clk);
    check("R4 fin single pulse", {63'd0, fin}, 64'd0);
    check("R8 product held", prod, {{W{1'b0}}, a} * {{W{1'b0}}, b});
    repeat (3) @(negedge clk);
    check("R8 product held later", prod, {{W{1'b0}}, a} * {{W{1'b0}}, b});
  endtask

  // monitor: R5 compare on fin
  always @(negedge clk) if (rst_n && fin) begin
    if (expq.size() == 0) check("R4 unexpected fin", 64'd1, 64'd0);
    else check("R5 product", prod, expq.pop_front());
  end

  initial begin
    #2000000;
    watchdog_hit = 1;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 busy reset", {63'd0, busy}, 64'd0);
    check("R1 fin reset", {63'd0, fin}, 64'd0);
    check("R1 prod reset", prod, 64'd0);
    rst_n = 1;
    run(32'd12, 32'd13, 0);
    run(32'd0, 32'hDEADBEEF, 0);
    run(32'hDEADBEEF, 32'd0, 0);
    run('1, '1, 0);
    @(negedge clk);
    check("R6 carry kept", prod, 64'hFFFFFFFE00000001);
    run(32'h80000000, 32'h80000000, 0);
    run(32'd1, 32'hFFFFFFFF, 0);
    run(32'hFFFF0001, 32'hF0F0F0F0, 1); // R7 poke mid-run
    run(32'h12345678, 32'h9ABCDEF0, 1); // R7
    for (int k = 0; k < 8; k++)
      run(32'h1 << (k * 4), 32'hFEDC_BA98 ^ (k * 32'h1111), 0);
    repeat (3) @(negedge clk);
    check("R5 queue drained", 64'(expq.size()), 64'd0);
    if (!watchdog_hit) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule